// File: doc/BRIEF.md
# Dual-Master Lock Grant Interrupt Unit

This block holds a bank of hardware lock bits shared by two masters, a main CPU and a coprocessor. Each master asks for locks by pulsing a get strobe with a bit mask and gives them back by pulsing a put strobe with a bit mask. A lock that is free is handed over at once. A lock that the other master holds is remembered as a waiting request and is handed over automatically once the holder lets it go. The hardware gives no lock a fixed meaning; software decides what each bit guards.

For each master the block keeps a grant status word, where a set bit means "this master now holds that lock", and an interrupt mask word. A simple valid/write/address/data port reads both words and writes the mask words. Each master has one level interrupt line, which is high while any held lock has its mask bit set. A master can therefore queue a request on a busy lock and sleep until the interrupt says the lock is its own, with no polling.

Top module: `sema_grant_irq`

## Requirements
- R1: A get pulse with mask M grants, at that clock edge, every bit of M that neither master holds; the status word of the requester shows those bits from the next cycle, and any number of bits may be asked for in one pulse.
- R2: No lock bit is ever held by both masters at once.
- R3: A get on a bit that the other master holds is kept as a waiting request; the bit is granted to the waiting master at the first clock edge after the edge at which the holder released it, so it appears in the status word two cycles after the release pulse.
- R4: When both masters want the same free bit at the same edge (new get or waiting request), the CPU gets it and the coprocessor's request stays waiting.
- R5: A put pulse clears the writer's status bit, and releases the lock, for every bit of its mask that the writer holds; mask bits the writer does not hold change nothing.
- R6: A get on a bit the requester already holds is ignored: no waiting request is created, and after the bit is released it stays free.
- R7: Register offsets are fixed: CPU status 0x0, CPU interrupt mask 0x4, coprocessor status 0x8, coprocessor interrupt mask 0xC. Writes to either status offset are ignored.
- R8: Both interrupt mask words are fully writable and read back the value last written.
- R9: Each interrupt line is high exactly while some bit is set in both the master's status word and its mask word, and stays high until that status bit is cleared or masked.
- R10: Reset clears all holdings, waiting requests, status words, mask words and both interrupt lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | N_LOCK | Write data |
| reg_rdata | output | N_LOCK | Read data for reg_addr (combinational) |
| cpu_get_valid | input | 1 | CPU lock request pulse |
| cpu_get_mask | input | N_LOCK | Locks requested by the CPU |
| cpu_put_valid | input | 1 | CPU lock release pulse |
| cpu_put_mask | input | N_LOCK | Locks released by the CPU |
| cop_get_valid | input | 1 | Coprocessor lock request pulse |
| cop_get_mask | input | N_LOCK | Locks requested by the coprocessor |
| cop_put_valid | input | 1 | Coprocessor lock release pulse |
| cop_put_mask | input | N_LOCK | Locks released by the coprocessor |
| cpu_irq | output | 1 | CPU grant interrupt, level |
| cop_irq | output | 1 | Coprocessor grant interrupt, level |

## Verification
The bench targets the hand-over of a busy lock: a design that granted in the release cycle itself would show the waiting master's bit one cycle early, and one that dropped the waiting request would never show it. It drives both masters at one free lock in the same cycle, where a wrong priority gives the bit to the coprocessor or to both, and it releases bits that the writer does not hold, which a careless design would free from under the other master. It re-requests an already held lock, where a design that queued the request would hand the bit back to its own master after release, and it writes the read-only status offsets, which a loose decoder would let overwrite the grant state.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

   // byte offsets of the four registers
   localparam int unsigned OFS_CPU_STAT = 'h0;
   localparam int unsigned OFS_CPU_MASK = 'h4;
   localparam int unsigned OFS_COP_STAT = 'h8;
   localparam int unsigned OFS_COP_MASK = 'hC;

   typedef enum logic [1:0] {
      SEL_CPU_STAT = 2'd0,
      SEL_CPU_MASK = 2'd1,
      SEL_COP_STAT = 2'd2,
      SEL_COP_MASK = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/sgi_lock_cell.sv
// One lock bit: holder flags and waiting-request flags for both masters.
module sgi_lock_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic get_cpu,
   input  logic get_cop,
   input  logic put_cpu,
   input  logic put_cop,
   output logic held_cpu,
   output logic held_cop
);

   logic wait_cpu, wait_cop;
   logic is_free, want_cpu, want_cop, win_cpu, win_cop;

   always_comb begin
      is_free  = ~held_cpu & ~held_cop;
      want_cpu = get_cpu | wait_cpu;
      want_cop = get_cop | wait_cop;
      win_cpu  = is_free & want_cpu;
      win_cop  = is_free & want_cop & ~want_cpu;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_cpu <= 1'b0;
         held_cop <= 1'b0;
         wait_cpu <= 1'b0;
         wait_cop <= 1'b0;
      end else begin
         held_cpu <= (held_cpu & ~put_cpu) | win_cpu;
         held_cop <= (held_cop & ~put_cop) | win_cop;
         wait_cpu <= (wait_cpu | (get_cpu & ~held_cpu)) & ~win_cpu;
         wait_cop <= (wait_cop | (get_cop & ~held_cop)) & ~win_cop;
      end
   end

endmodule

// File: rtl/sgi_regs.sv
// Interrupt mask words and the register read path.
module sgi_regs #(
   parameter int unsigned N_LOCK = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [N_LOCK-1:0] reg_wdata,
   input  logic [N_LOCK-1:0] stat_cpu,
   input  logic [N_LOCK-1:0] stat_cop,
   output logic [N_LOCK-1:0] mask_cpu,
   output logic [N_LOCK-1:0] mask_cop,
   output logic [N_LOCK-1:0] reg_rdata
);
   import sgi_pkg::*;

   logic     hit;
   reg_sel_e sel;

   always_comb begin
      hit = 1'b1;
      sel = SEL_CPU_STAT;
      if (reg_addr == ADDR_W'(OFS_CPU_STAT))      sel = SEL_CPU_STAT;
      else if (reg_addr == ADDR_W'(OFS_CPU_MASK)) sel = SEL_CPU_MASK;
      else if (reg_addr == ADDR_W'(OFS_COP_STAT)) sel = SEL_COP_STAT;
      else if (reg_addr == ADDR_W'(OFS_COP_MASK)) sel = SEL_COP_MASK;
      else                                        hit = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_cpu <= '0;
         mask_cop <= '0;
      end else if (reg_valid && reg_write && hit) begin
         if (sel == SEL_CPU_MASK) mask_cpu <= reg_wdata;
         if (sel == SEL_COP_MASK) mask_cop <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit) begin
         unique case (sel)
            SEL_CPU_STAT: reg_rdata = stat_cpu;
            SEL_CPU_MASK: reg_rdata = mask_cpu;
            SEL_COP_STAT: reg_rdata = stat_cop;
            SEL_COP_MASK: reg_rdata = mask_cop;
         endcase
      end
   end

endmodule

// File: rtl/sgi_irq.sv
// Masked OR of the grant word; optional output flop.
module sgi_irq #(
   parameter int unsigned N_LOCK   = 32,
   parameter bit          IRQ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_LOCK-1:0] stat,
   input  logic [N_LOCK-1:0] mask,
   output logic              irq
);

   logic any_hit;
   assign any_hit = |(stat & mask);

   generate
      if (IRQ_FLOP) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= any_hit;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign irq = any_hit;
      end
   endgenerate

endmodule

// File: rtl/sema_grant_irq.sv
module sema_grant_irq #(
   parameter int unsigned N_LOCK   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter bit          IRQ_FLOP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_valid,
   input  logic              reg_write,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [N_LOCK-1:0] reg_wdata,
   output logic [N_LOCK-1:0] reg_rdata,
   input  logic              cpu_get_valid,
   input  logic [N_LOCK-1:0] cpu_get_mask,
   input  logic              cpu_put_valid,
   input  logic [N_LOCK-1:0] cpu_put_mask,
   input  logic              cop_get_valid,
   input  logic [N_LOCK-1:0] cop_get_mask,
   input  logic              cop_put_valid,
   input  logic [N_LOCK-1:0] cop_put_mask,
   output logic              cpu_irq,
   output logic              cop_irq
);

   generate
      if (N_LOCK < 1) begin : g_bad_n
         $error("sema_grant_irq: N_LOCK must be at least 1");
      end
      if (ADDR_W < 4) begin : g_bad_a
         $error("sema_grant_irq: ADDR_W must be at least 4");
      end
   endgenerate

   logic [N_LOCK-1:0] get_cpu_v, get_cop_v, put_cpu_v, put_cop_v;
   logic [N_LOCK-1:0] own_cpu, own_cop;
   logic [N_LOCK-1:0] en_cpu, en_cop;

   assign get_cpu_v = cpu_get_valid ? cpu_get_mask : '0;
   assign get_cop_v = cop_get_valid ? cop_get_mask : '0;
   assign put_cpu_v = cpu_put_valid ? cpu_put_mask : '0;
   assign put_cop_v = cop_put_valid ? cop_put_mask : '0;

   generate
      for (genvar i = 0; i < N_LOCK; i++) begin : g_lock
         sgi_lock_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .get_cpu  (get_cpu_v[i]),
            .get_cop  (get_cop_v[i]),
            .put_cpu  (put_cpu_v[i]),
            .put_cop  (put_cop_v[i]),
            .held_cpu (own_cpu[i]),
            .held_cop (own_cop[i])
         );
      end
   endgenerate

   sgi_regs #(.N_LOCK(N_LOCK), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_valid (reg_valid),
      .reg_write (reg_write),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .stat_cpu  (own_cpu),
      .stat_cop  (own_cop),
      .mask_cpu  (en_cpu),
      .mask_cop  (en_cop),
      .reg_rdata (reg_rdata)
   );

   sgi_irq #(.N_LOCK(N_LOCK), .IRQ_FLOP(IRQ_FLOP)) u_irq_cpu (
      .clk   (clk),
      .rst_n (rst_n),
      .stat  (own_cpu),
      .mask  (en_cpu),
      .irq   (cpu_irq)
   );

   sgi_irq #(.N_LOCK(N_LOCK), .IRQ_FLOP(IRQ_FLOP)) u_irq_cop (
      .clk   (clk),
      .rst_n (rst_n),
      .stat  (own_cop),
      .mask  (en_cop),
      .irq   (cop_irq)
   );

endmodule

// File: rtl/sgi_chk.sv
module sgi_chk #(
   parameter int unsigned N_LOCK   = 32,
   parameter int unsigned ADDR_W   = 4,
   parameter bit          IRQ_FLOP = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_valid,
   input logic              reg_write,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              cpu_put_valid,
   input logic [N_LOCK-1:0] cpu_put_mask,
   input logic              cop_put_valid,
   input logic [N_LOCK-1:0] cop_put_mask,
   input logic [N_LOCK-1:0] own_cpu,
   input logic [N_LOCK-1:0] own_cop,
   input logic              cpu_irq
);

   // R2
   no_double_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_cpu & own_cop) == '0);

   // R5
   cpu_put_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_put_valid |=> ((own_cpu & $past(cpu_put_mask & own_cpu)) == '0));

   // R5
   cop_put_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cop_put_valid |=> ((own_cop & $past(cop_put_mask & own_cop)) == '0));

   // R3
   cpu_grant_from_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((own_cpu & ~$past(own_cpu) & $past(own_cop)) == '0));

   // R3
   cop_grant_from_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((own_cop & ~$past(own_cop) & $past(own_cpu)) == '0));

   generate
      if (!IRQ_FLOP) begin : g_lvl
         // R9
         cpu_irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_irq && !cpu_put_valid && !(reg_valid && reg_write && reg_addr == ADDR_W'('h4)))
            |=> cpu_irq);
      end
   endgenerate

endmodule

bind sema_grant_irq sgi_chk #(.N_LOCK(N_LOCK), .ADDR_W(ADDR_W), .IRQ_FLOP(IRQ_FLOP)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_valid     (reg_valid),
   .reg_write     (reg_write),
   .reg_addr      (reg_addr),
   .cpu_put_valid (cpu_put_valid),
   .cpu_put_mask  (cpu_put_mask),
   .cop_put_valid (cop_put_valid),
   .cop_put_mask  (cop_put_mask),
   .own_cpu       (own_cpu),
   .own_cop       (own_cop),
   .cpu_irq       (cpu_irq)
);

// File: tb/tb_sema_grant_irq.sv
`timescale 1ns/1ps
module tb_sema_grant_irq;

   localparam int N = 32;
   localparam int A = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_valid = 1'b0, reg_write = 1'b0;
   logic [A-1:0] reg_addr = '0;
   logic [N-1:0] reg_wdata = '0;
   logic [N-1:0] reg_rdata;
   logic         cpu_get_valid = 1'b0, cpu_put_valid = 1'b0;
   logic         cop_get_valid = 1'b0, cop_put_valid = 1'b0;
   logic [N-1:0] cpu_get_mask = '0, cpu_put_mask = '0;
   logic [N-1:0] cop_get_mask = '0, cop_put_mask = '0;
   logic         cpu_irq, cop_irq;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   sema_grant_irq dut (
      .clk(clk), .rst_n(rst_n),
      .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_get_valid(cpu_get_valid), .cpu_get_mask(cpu_get_mask),
      .cpu_put_valid(cpu_put_valid), .cpu_put_mask(cpu_put_mask),
      .cop_get_valid(cop_get_valid), .cop_get_mask(cop_get_mask),
      .cop_put_valid(cop_put_valid), .cop_put_mask(cop_put_mask),
      .cpu_irq(cpu_irq), .cop_irq(cop_irq)
   );

   // each row: cpu get, cop get, cpu put, cop put, expected cpu status, expected cop status
   localparam int NV = 18;
   localparam logic [6*N-1:0] VEC [0:NV-1] = '{
      {32'h0000_0003, 32'h0,          32'h0,          32'h0,          32'h0000_0003, 32'h0},           // R1
      {32'h0,          32'h0000_0006, 32'h0,          32'h0,          32'h0000_0003, 32'h0000_0004},   // R3 wait on bit1
      {32'h0,          32'h0,          32'h0000_0002, 32'h0,          32'h0000_0001, 32'h0000_0004},   // R3 not yet
      {32'h0,          32'h0,          32'h0,          32'h0,          32'h0000_0001, 32'h0000_0006},   // R3 handed over
      {32'h0000_0010, 32'h0000_0010, 32'h0,          32'h0,          32'h0000_0011, 32'h0000_0006},   // R4
      {32'h0,          32'h0,          32'h0,          32'h0000_0001, 32'h0000_0011, 32'h0000_0006},   // R5 foreign put
      {32'h0000_0001, 32'h0,          32'h0,          32'h0,          32'h0000_0011, 32'h0000_0006},   // R6
      {32'h0,          32'h0,          32'h0000_0011, 32'h0,          32'h0,          32'h0000_0006},   // R5
      {32'h0,          32'h0,          32'h0,          32'h0,          32'h0,          32'h0000_0016},   // R6 bit0 stays free
      {32'h8000_0000, 32'h4000_0000, 32'h0,          32'h0,          32'h8000_0000, 32'h4000_0016},   // R1
      {32'h0,          32'h0,          32'h8000_0000, 32'h4000_0016, 32'h0,          32'h0},           // R5
      {32'h0,          32'hFFFF_FFFF, 32'h0,          32'h0,          32'h0,          32'hFFFF_FFFF},   // R1
      {32'h0000_00F0, 32'h0,          32'h0,          32'h0,          32'h0,          32'hFFFF_FFFF},   // R3
      {32'h0,          32'h0,          32'h0,          32'h0000_00F0, 32'h0,          32'hFFFF_FF0F},   // R3
      {32'h0,          32'h0,          32'h0,          32'h0,          32'h0000_00F0, 32'hFFFF_FF0F},   // R3
      {32'h0,          32'h0000_00F0, 32'h0000_00F0, 32'h0,          32'h0,          32'hFFFF_FF0F},   // R3
      {32'h0,          32'h0,          32'h0,          32'h0,          32'h0,          32'hFFFF_FFFF},   // R3
      {32'h0,          32'h0,          32'h0,          32'hFFFF_FFFF, 32'h0,          32'h0}            // R5
   };
   localparam string VTAG [0:NV-1] = '{
      "R1", "R3", "R3", "R3", "R4", "R5", "R6", "R5", "R6",
      "R1", "R5", "R1", "R3", "R3", "R3", "R3", "R3", "R5"
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input string what,
                        input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic rd(input logic [A-1:0] a, output logic [N-1:0] d);
      reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
      #1;
      d = reg_rdata;
      reg_valid = 1'b0;
   endtask

   task automatic wr(input logic [A-1:0] a, input logic [N-1:0] d);
      reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
      tick();
      reg_valid = 1'b0; reg_write = 1'b0;
   endtask

   task automatic pulse(input logic [N-1:0] cg, input logic [N-1:0] pg,
                        input logic [N-1:0] cp, input logic [N-1:0] pp);
      cpu_get_valid = |cg; cpu_get_mask = cg;
      cop_get_valid = |pg; cop_get_mask = pg;
      cpu_put_valid = |cp; cpu_put_mask = cp;
      cop_put_valid = |pp; cop_put_mask = pp;
      tick();
      cpu_get_valid = 1'b0; cop_get_valid = 1'b0;
      cpu_put_valid = 1'b0; cop_put_valid = 1'b0;
      cpu_get_mask = '0; cop_get_mask = '0; cpu_put_mask = '0; cop_put_mask = '0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   initial begin
      logic [N-1:0] d;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R10 reset state
      rd(4'h0, d); check("R10", "cpu status after reset", d, '0);
      rd(4'h4, d); check("R10", "cpu mask after reset", d, '0);
      rd(4'h8, d); check("R10", "cop status after reset", d, '0);
      rd(4'hC, d); check("R10", "cop mask after reset", d, '0);
      check("R10", "irq lines after reset", {30'd0, cpu_irq, cop_irq}, '0);

      for (int v = 0; v < NV; v++) begin
         pulse(VEC[v][6*N-1:5*N], VEC[v][5*N-1:4*N], VEC[v][4*N-1:3*N], VEC[v][3*N-1:2*N]);
         rd(4'h0, d); check(VTAG[v], $sformatf("vector %0d cpu status", v), d, VEC[v][2*N-1:N]);
         rd(4'h8, d); check(VTAG[v], $sformatf("vector %0d cop status", v), d, VEC[v][N-1:0]);
      end

      // R8 mask words
      wr(4'h4, 32'h0000_0005);
      rd(4'h4, d); check("R8", "cpu mask readback", d, 32'h0000_0005);
      wr(4'hC, 32'hFFFF_0004);
      rd(4'hC, d); check("R8", "cop mask readback", d, 32'hFFFF_0004);

      // R7 status offsets ignore writes
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, d); check("R7", "cpu status after write", d, '0);
      wr(4'h8, 32'hFFFF_FFFF);
      rd(4'h8, d); check("R7", "cop status after write", d, '0);
      rd(4'h4, d); check("R7", "cpu mask unchanged", d, 32'h0000_0005);

      // R9 interrupt on grant
      pulse(32'h4, '0, '0, '0);
      check("R9", "cpu irq on enabled grant", {31'd0, cpu_irq}, 32'd1);
      pulse('0, 32'h4, '0, '0);
      check("R3", "cop irq while waiting", {31'd0, cop_irq}, 32'd0);
      tick();
      check("R9", "cpu irq held", {31'd0, cpu_irq}, 32'd1);
      pulse('0, '0, 32'h4, '0);
      check("R9", "cpu irq cleared by put", {31'd0, cpu_irq}, 32'd0);
      check("R3", "cop irq not in release cycle", {31'd0, cop_irq}, 32'd0);
      tick();
      check("R3", "cop irq after hand-over", {31'd0, cop_irq}, 32'd1);
      rd(4'h8, d); check("R3", "cop status after hand-over", d, 32'h4);

      pulse(32'h2, '0, '0, '0);
      check("R9", "cpu irq masked grant", {31'd0, cpu_irq}, 32'd0);
      rd(4'h0, d); check("R1", "cpu status masked grant", d, 32'h2);
      pulse('0, '0, '0, 32'h4);
      check("R9", "cop irq cleared by put", {31'd0, cop_irq}, 32'd0);

      // R9 mask write lowers a raised line
      wr(4'h4, 32'h0000_0002);
      check("R9", "cpu irq after unmasking", {31'd0, cpu_irq}, 32'd1);
      wr(4'h4, 32'h0);
      check("R9", "cpu irq after masking", {31'd0, cpu_irq}, 32'd0);

      // R10 reset mid-run
      wr(4'hC, 32'h1234_5678);
      rst_n = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      rd(4'h0, d); check("R10", "cpu status after reset", d, '0);
      rd(4'hC, d); check("R10", "cop mask after reset", d, '0);
      pulse('0, 32'h2, '0, '0);
      rd(4'h8, d); check("R10", "lock free after reset", d, 32'h2);

      finish_run();
   end

endmodule